// File: doc/BRIEF.md
# Zero-Count Down Timer

This block is a programmable down-counter driven by a one-cycle tick strobe. Software sets a start value while the timer is stopped, then turns on the enable bit. Each tick lowers the count by one until it reaches zero. When the zero-interrupt enable is on, reaching zero latches a pending flag. That flag drives a level interrupt, which stays high until software writes a one to clear it.

With the reload select on, the tick that follows zero restores the last start value that was accepted, so the timer runs periodically. With reload off, the count stays at zero. Register access uses a simple single-cycle bus. A select and write strobe, an address and write data make a write. Read data comes back combinationally from the address. The tick source and the interrupt controller are outside this block.

Top module: `zc_timer`

## Requirements
- R1: After reset, the control word and the count both read 0, and irq_o is low.
- R2: The control word is at offset 0x0. Its fields are: bit 5 enable, bit 2 reload select, bit 1 zero-interrupt enable, bit 0 pending flag. All other bits are ignored on write and read as 0.
- R3: The count is at offset 0x4. A write to it while the enable is 0 sets the live count and also stores the reload value. Reads return the live count in the low CNT_W bits, and the upper bits read 0.
- R4: A write to the count while the enable is 1 changes neither the live count nor the stored reload value.
- R5: While enabled, each tick lowers a non-zero count by exactly one. The count does not change without a tick, and it does not change while disabled.
- R6: With reload select 0, a tick at count 0 leaves the count at 0.
- R7: With reload select 1, a tick at count 0 loads the stored reload value.
- R8: A tick that takes the count from 1 to 0 while the zero-interrupt enable is 1 sets the pending flag. irq_o equals the pending flag.
- R9: With the zero-interrupt enable at 0, reaching zero does not set the pending flag.
- R10: Writing 1 to bit 0 of the control word clears the pending flag. Writing 0 there leaves it unchanged, so irq_o stays high until a clearing write.
- R11: When a zero-reaching tick and a clearing write fall in the same cycle, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle count strobe |
| sel_i | input | 1 | Register access select |
| we_i | input | 1 | Write strobe (with sel_i) |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| irq_o | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The bench uses the default parameters: a 24-bit count inside a 32-bit data word, with a 4-bit address. At full counter width, an all-ones write shows that bits 31 to 24 are dropped. Small start values such as 1, 2 and 3 reach zero within a few ticks. This makes the zero crossing, the hold-at-zero case, the reload case and the tick-versus-clear collision each reachable in a short directed run.

// File: rtl/zc_timer_pkg.sv
package zc_timer_pkg;
  localparam int unsigned BIT_EN     = 5;
  localparam int unsigned BIT_RELOAD = 2;
  localparam int unsigned BIT_ZIEN   = 1;
  localparam int unsigned BIT_PEND   = 0;

  typedef struct packed {
    logic en;
    logic reload;
    logic zien;
  } ctrl_t;
endpackage

// File: rtl/zc_timer_regif.sv
module zc_timer_regif
  import zc_timer_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned VAL_OFS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              pend_i,
  output ctrl_t             ctrl_o,
  output logic              ctrl_wr_o,
  output logic              val_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] VAL_A  = ADDR_W'(VAL_OFS);

  ctrl_t ctrl_q;

  assign ctrl_wr_o = sel_i && we_i && (addr_i == CTRL_A);
  assign val_wr_o  = sel_i && we_i && (addr_i == VAL_A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr_o) begin
      ctrl_q.en     <= wdata_i[BIT_EN];
      ctrl_q.reload <= wdata_i[BIT_RELOAD];
      ctrl_q.zien   <= wdata_i[BIT_ZIEN];
    end
  end

  assign ctrl_o = ctrl_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_A) begin
      rdata_o[BIT_EN]     = ctrl_q.en;
      rdata_o[BIT_RELOAD] = ctrl_q.reload;
      rdata_o[BIT_ZIEN]   = ctrl_q.zien;
      rdata_o[BIT_PEND]   = pend_i;
    end else if (addr_i == VAL_A) begin
      rdata_o[CNT_W-1:0]  = count_i;
    end
  end
endmodule

// File: rtl/zc_timer_counter.sv
module zc_timer_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_val_o,
  output logic             zero_hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q, rl_q;
  logic             step, at_zero, accept;

  assign accept     = load_i && !en_i;
  assign step       = en_i && tick_i;
  assign at_zero    = (count_q == '0);
  assign zero_hit_o = step && (count_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      rl_q    <= '0;
    end else if (accept) begin
      count_q <= load_val_i;
      rl_q    <= load_val_i;
    end else if (step) begin
      if (!at_zero)      count_q <= count_q - ONE;
      else if (reload_i) count_q <= rl_q;
    end
  end

  assign count_o      = count_q;
  assign reload_val_o = rl_q;
endmodule

// File: rtl/zc_timer_irq.sv
module zc_timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zien_i,
  input  logic zero_hit_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pend_q <= 1'b0;
    else if (zero_hit_i && zien_i) pend_q <= 1'b1;  // set wins over clear
    else if (clr_i)                pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/zc_timer.sv
module zc_timer
  import zc_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic             ctrl_wr, val_wr, zero_hit, pend;
  logic [CNT_W-1:0] count, reload_val;
  logic             en_w, reload_w, zien_w;

  assign en_w     = ctrl.en;
  assign reload_w = ctrl.reload;
  assign zien_w   = ctrl.zien;

  zc_timer_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_regif (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .count_i(count), .pend_i(pend),
    .ctrl_o(ctrl), .ctrl_wr_o(ctrl_wr), .val_wr_o(val_wr), .rdata_o(rdata_o)
  );

  zc_timer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_w), .reload_i(reload_w),
    .tick_i(tick_i), .load_i(val_wr), .load_val_i(wdata_i[CNT_W-1:0]),
    .count_o(count), .reload_val_o(reload_val), .zero_hit_o(zero_hit)
  );

  zc_timer_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .zien_i(zien_w), .zero_hit_i(zero_hit),
    .clr_i(ctrl_wr && wdata_i[BIT_PEND]), .pend_o(pend)
  );

  assign irq_o = pend;
endmodule

// File: rtl/zc_timer_chk.sv
module zc_timer_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic              en,
  input logic              reload,
  input logic              zien,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload_val
);
  logic val_wr, clr_wr;
  assign val_wr = sel_i && we_i && (addr_i == ADDR_W'(4));
  assign clr_wr = sel_i && we_i && (addr_i == ADDR_W'(0)) && wdata_i[0];

  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !val_wr) |=> $stable(count)); // R5
  AST_LOCKED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && val_wr && !tick_i) |=> ($stable(count) && $stable(reload_val))); // R4
  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && tick_i && count != '0) |=> (count == $past(count) - CNT_W'(1))); // R5
  AST_ZERO_STICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && tick_i && count == '0 && !reload) |=> (count == '0)); // R6
  AST_RELOAD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && tick_i && count == '0 && reload) |=> (count == $past(reload_val))); // R7
  AST_ZERO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && tick_i && zien && count == CNT_W'(1)) |=> irq_o); // R8
  AST_IRQ_NEEDS_ZIEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(zien)); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr) |=> irq_o); // R10

  always_comb begin
    if (rst_ni && addr_i == ADDR_W'(4))
      AST_UPPER_ZERO: assert (rdata_o[DATA_W-1:CNT_W] == '0); // R3
  end
endmodule

bind zc_timer zc_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .sel_i(sel_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .en(en_w), .reload(reload_w), .zien(zien_w), .count(count),
  .reload_val(reload_val)
);

// File: tb/zc_timer_bench.sv
module zc_timer_bench;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 24;
  localparam logic [ADDR_W-1:0] A_CTL = 4'h0;
  localparam logic [ADDR_W-1:0] A_VAL = 4'h4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, sel = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  zc_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_zc_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input bit t = 0);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d; tick = t;
    @(negedge clk);
    sel = 0; we = 0; tick = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTL, d); chk("R1 ctrl", d, 0);
    rd(A_VAL, d); chk("R1 count", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, d); chk("R2 fields", d, 32'h26);
    wr(A_CTL, 0);
    rd(A_CTL, d); chk("R2 cleared", d, 0);
  endtask

  task automatic t_value();
    logic [31:0] d;
    wr(A_VAL, 32'hABCD_EF12);
    rd(A_VAL, d); chk("R3 load", d, 32'h00CD_EF12);
    pulse();
    rd(A_VAL, d); chk("R5 disabled tick", d, 32'h00CD_EF12);
    wr(A_VAL, 32'hFFFF_FFFF);
    rd(A_VAL, d); chk("R3 upper zero", d, 32'h00FF_FFFF);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(A_VAL, 3);
    wr(A_CTL, 32'h20);
    pulse(); rd(A_VAL, d); chk("R5 dec", d, 2);
    repeat (3) @(negedge clk);
    rd(A_VAL, d); chk("R5 no tick", d, 2);
    wr(A_VAL, 9);
    rd(A_VAL, d); chk("R4 locked", d, 2);
    pulse(); pulse();
    rd(A_VAL, d); chk("R5 to zero", d, 0);
    chk("R9 no irq", {31'd0, irq}, 0);
    pulse();
    rd(A_VAL, d); chk("R6 hold zero", d, 0);
    wr(A_CTL, 32'h24);
    pulse();
    rd(A_VAL, d); chk("R7 R4 reload keeps first value", d, 3);
    wr(A_CTL, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(A_VAL, 2);
    wr(A_CTL, 32'h22);
    pulse(); chk("R8 not yet", {31'd0, irq}, 0);
    pulse(); chk("R8 irq", {31'd0, irq}, 1);
    rd(A_CTL, d); chk("R8 pend bit", d, 32'h23);
    repeat (4) @(negedge clk);
    wr(A_CTL, 32'h22);
    chk("R10 write zero keeps", {31'd0, irq}, 1);
    wr(A_CTL, 32'h23);
    chk("R10 clear", {31'd0, irq}, 0);
    rd(A_CTL, d); chk("R10 fields kept", d, 32'h22);
    wr(A_CTL, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wr(A_VAL, 1);
    wr(A_CTL, 32'h26);
    pulse(); chk("R8 periodic irq", {31'd0, irq}, 1);
    pulse(); rd(A_VAL, d); chk("R7 reload", d, 1);
    pulse(); rd(A_VAL, d); chk("R7 second zero", d, 0);
    wr(A_CTL, 32'h01);
    chk("R10 clear periodic", {31'd0, irq}, 0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(A_VAL, 1);
    wr(A_CTL, 32'h23);
    wr(A_CTL, 32'h23, 1);
    chk("R11 set wins", {31'd0, irq}, 1);
    rd(A_VAL, d); chk("R11 count", d, 0);
    wr(A_CTL, 32'h23);
    chk("R11 later clear", {31'd0, irq}, 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_value();
    t_count();
    t_irq();
    t_periodic();
    t_race();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule